// File: doc/BRIEF.md
# Interrupt Status and Enable Register Bank

This block keeps a controller's interrupt state in a single 32-bit register: eight sticky status flags in the low byte and their eight enable flags directly above them. Event pulses from the bus sequencer set the status flags, which stay set until software clears them. The AND of status, enable and a fixed mask of the sources that matter in master operation drives one interrupt line.

Each register is reached at three addresses. A write to the base address loads the register. A write to base + 0x4 sets the bits that are one in the data. A write to base + 0x8 clears the bits that are one in the data. Software can therefore change a single flag without a read-modify-write. A separate control register carries a soft reset in bit 31. Setting that bit wipes all status and enable flags, and the bit then drops back to zero by itself.

Top module: `irq_status_regs`

## Requirements
- R1: After the synchronous reset, reads of both registers return 0 and `irq` is low.
- R2: A write to the interrupt register's base address (default 0x40) loads status from data bits 7:0 and enables from data bits 15:8. Bits 31:16 always read as zero.
- R3: A write to base + 0x4 sets only the bits that are one in the data. A write to base + 0x8 clears only the bits that are one in the data. All other bits keep their value.
- R4: A one on `evt_pulse[i]` sets status bit i. The bit stays set through idle cycles until a write clears it.
- R5: If an event and a write that would clear the same status bit fall in one cycle, the status bit ends up set.
- R6: `irq` is high when a status bit and its enable bit are both one for a source among bits 6, 5, 3, 2, 1 and 0. Status bits 7 (bus free) and 4 (oversize transfer) never raise `irq`.
- R7: A read at base + 0x4 or base + 0x8 returns the same value as a read at the base address.
- R8: Writing a one to bit 31 of the control register (base 0x00 or its set alias 0x04) makes bit 31 read as 1 for one cycle. On the next edge every status and enable bit is cleared and bit 31 returns to 0. Writing 0 to bit 31 has no effect.
- R9: Writes to addresses outside both register triplets change nothing, and reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| evt_pulse | input | 8 | One-cycle event pulses, one per status source |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the same-cycle collision of an event and a clear. A design that gave priority to the clear would lose the event, and the status bit would read back as zero. It also enables the two sources that are outside the master-mode mask and fires both. If the mask were wrong, `irq` would rise. The soft reset is checked in the cycle after the write, when bit 31 must still read as one, and again one cycle later, when it must be gone. A bit that never self-clears, or a reset that misses the enable byte, shows up there. Writes to unmapped addresses and writes that leave bit 31 at zero are followed by read-backs, which would expose a loose address decode.

// File: rtl/irqr_pkg.sv
// Shared types for the interrupt register bank.
// Assumes: the three access flavours of a register are distinguished only by address.
package irqr_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLR   = 2'd3
    } reg_op_e;
endpackage

// File: rtl/irqr_alias_decode.sv
// Maps an address onto the access flavour of one register triplet:
// base = load, base+4 = set bits, base+8 = clear bits.
// Assumes: BASE is 4-byte aligned and BASE+8 fits in ADDR_W bits.
module irqr_alias_decode
    import irqr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BASE   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_op_e           op
);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE + 4);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + 8);

    // Select the access flavour from the address.
    always_comb begin
        if (addr == A_LOAD)     op = OP_WRITE;
        else if (addr == A_SET) op = OP_SET;
        else if (addr == A_CLR) op = OP_CLR;
        else                    op = OP_NONE;
    end
endmodule

// File: rtl/irqr_bitreg.sv
// A vector of flag bits that can be loaded, set or cleared by a register op.
// Per-bit event inputs set a flag and win over any clear in the same cycle.
// The soft reset input clears every bit and has the highest priority.
// Assumes: op is already qualified by the write strobe.
module irqr_bitreg
    import irqr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  reg_op_e      op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic nxt;

        // Next value of one flag from the register op, before events.
        always_comb begin
            unique case (op)
                OP_WRITE: nxt = wdata[i];
                OP_SET:   nxt = q[i] | wdata[i];
                OP_CLR:   nxt = q[i] & ~wdata[i];
                default:  nxt = q[i];
            endcase
        end

        // Flag storage: soft reset, then event, then register op.
        always_ff @(posedge clk) begin
            if (!rst_n || srst) q[i] <= 1'b0;
            else                q[i] <= nxt | evt[i];
        end
    end
endmodule

// File: rtl/irqr_soft_reset.sv
// Soft reset flag of the control register. A load or set that writes a one
// to the flag raises it, and it drops back to zero on the following edge.
// Assumes: the consumer clears its state on the edge where the flag is high.
module irqr_soft_reset
    import irqr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  reg_op_e op,
    input  logic    wbit,
    output logic    srst_q
);
    logic req;

    // A request comes from a load or set alias carrying a one.
    assign req = wbit && (op == OP_WRITE || op == OP_SET);

    // Raise the flag on a request and clear it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)      srst_q <= 1'b0;
        else if (srst_q) srst_q <= 1'b0;
        else             srst_q <= req;
    end
endmodule

// File: rtl/irq_status_regs.sv
// Interrupt status/enable register with load, set and clear aliases, plus
// a control register whose top bit is a self-clearing soft reset.
// Status flags sit in bits NUM_SRC-1:0 and enables in the NUM_SRC bits above.
// Assumes: one write per cycle, and reads are combinational on rd_addr.
module irq_status_regs
    import irqr_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DW        = 32,
    parameter int                NUM_SRC   = 8,
    parameter int                CTRL_BASE = 'h00,
    parameter int                IRQ_BASE  = 'h40,
    parameter logic [NUM_SRC-1:0] IRQ_MASK = 8'h6F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DW-1:0]      rd_data,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic               irq
);
    localparam int EN_LO   = NUM_SRC;
    localparam int EN_HI   = 2 * NUM_SRC - 1;
    localparam int PAD_W   = DW - 2 * NUM_SRC;
    localparam int SRST_B  = DW - 1;

    reg_op_e ctrl_op, irq_op, ctrl_wop, irq_wop, ctrl_rop, irq_rop;
    logic    srst_q;
    logic    irq_wr_any;
    logic    irq_rd_hit;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DW-2:2*NUM_SRC];

    irqr_alias_decode #(.ADDR_W(ADDR_W), .BASE(CTRL_BASE)) u_ctrl_wdec (
        .addr (wr_addr),
        .op   (ctrl_op)
    );

    irqr_alias_decode #(.ADDR_W(ADDR_W), .BASE(IRQ_BASE)) u_irq_wdec (
        .addr (wr_addr),
        .op   (irq_op)
    );

    irqr_alias_decode #(.ADDR_W(ADDR_W), .BASE(CTRL_BASE)) u_ctrl_rdec (
        .addr (rd_addr),
        .op   (ctrl_rop)
    );

    irqr_alias_decode #(.ADDR_W(ADDR_W), .BASE(IRQ_BASE)) u_irq_rdec (
        .addr (rd_addr),
        .op   (irq_rop)
    );

    // Qualify the write decodes with the strobe.
    always_comb begin
        ctrl_wop = wr_en ? ctrl_op : OP_NONE;
        irq_wop  = wr_en ? irq_op  : OP_NONE;
    end

    assign irq_wr_any = (irq_wop != OP_NONE);
    assign irq_rd_hit = (irq_rop != OP_NONE);

    irqr_soft_reset u_srst (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (ctrl_wop),
        .wbit   (wr_data[SRST_B]),
        .srst_q (srst_q)
    );

    irqr_bitreg #(.W(NUM_SRC)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .srst  (srst_q),
        .op    (irq_wop),
        .wdata (wr_data[NUM_SRC-1:0]),
        .evt   (evt_pulse),
        .q     (status)
    );

    irqr_bitreg #(.W(NUM_SRC)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .srst  (srst_q),
        .op    (irq_wop),
        .wdata (wr_data[EN_HI:EN_LO]),
        .evt   ({NUM_SRC{1'b0}}),
        .q     (enable)
    );

    // Interrupt line: enabled, pending sources that count in master mode.
    assign irq = |(status & enable & IRQ_MASK);

    // Read mux: all three aliases of a register return its value.
    always_comb begin
        if (ctrl_rop != OP_NONE)
            rd_data = {srst_q, {(DW-1){1'b0}}};
        else if (irq_rd_hit)
            rd_data = {{PAD_W{1'b0}}, enable, status};
        else
            rd_data = '0;
    end
endmodule

// File: rtl/irq_status_regs_chk.sv
// Property checker for the interrupt register bank, bound to its top.
// Assumes: it sees the internal flag vectors by name through the bind.
module irq_status_regs_chk #(
    parameter int                 DW       = 32,
    parameter int                 NUM_SRC  = 8,
    parameter logic [NUM_SRC-1:0] IRQ_MASK = 8'h6F
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srst_q,
    input logic               irq_wr_any,
    input logic               irq_rd_hit,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] enable,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic [DW-1:0]      rd_data,
    input logic               irq
);
    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q); // R8
    AST_SRST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (status == '0 && enable == '0)); // R8
    AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_q && evt_pulse != '0) |=> ((status & $past(evt_pulse)) == $past(evt_pulse))); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_q && !irq_wr_any) |=> ((status & $past(status)) == $past(status))); // R4
    AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((enable & IRQ_MASK) == '0) |-> !irq); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rd_hit |-> (rd_data[DW-1:2*NUM_SRC] == '0)); // R2
endmodule

bind irq_status_regs irq_status_regs_chk #(
    .DW       (DW),
    .NUM_SRC  (NUM_SRC),
    .IRQ_MASK (IRQ_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_q     (srst_q),
    .irq_wr_any (irq_wr_any),
    .irq_rd_hit (irq_rd_hit),
    .status     (status),
    .enable     (enable),
    .evt_pulse  (evt_pulse),
    .rd_data    (rd_data),
    .irq        (irq)
);

// File: tb/irq_status_regs_bench.sv
// Scoreboard bench: driver tasks push expected read/irq values into a queue,
// a monitor pops them just after each falling edge and compares.
module irq_status_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  evt_pulse = '0;
    logic        irq;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    irq_status_regs u_irq_status_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    // Monitor: compare queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rd_data;
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // One clock cycle of stimulus, driven from a falling edge.
    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [7:0] ev);
        wr_en = we; wr_addr = a; wr_data = d; evt_pulse = ev;
        @(negedge clk);
        wr_en = 1'b0; evt_pulse = '0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        rd_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_rd(8'h40, 32'h0, "R1 irq reg after reset");
        expect_rd(8'h00, 32'h0, "R1 ctrl reg after reset");
        expect_irq(1'b0, "R1 irq low after reset");

        cyc(1, 8'h40, 32'hFFFF_2A15, 8'h00);
        expect_rd(8'h40, 32'h0000_2A15, "R2 load, upper bits zero");
        expect_irq(1'b0, "R6 no overlap of status and enable");

        cyc(1, 8'h44, 32'h0000_0400, 8'h00);
        expect_rd(8'h40, 32'h0000_2E15, "R3 set alias");
        expect_irq(1'b1, "R6 enabled pending source 2");

        cyc(1, 8'h48, 32'h0000_0004, 8'h00);
        expect_rd(8'h40, 32'h0000_2E11, "R3 clear alias");
        expect_irq(1'b0, "R6 source 2 cleared");
        expect_rd(8'h44, 32'h0000_2E11, "R7 read at set alias");
        expect_rd(8'h48, 32'h0000_2E11, "R7 read at clear alias");

        cyc(1, 8'h40, 32'h0000_9000, 8'h00);
        cyc(0, 8'h00, 32'h0, 8'h90);
        expect_rd(8'h40, 32'h0000_9090, "R4 events on sources 7 and 4");
        expect_irq(1'b0, "R6 sources 7 and 4 excluded");

        cyc(0, 8'h00, 32'h0, 8'h02);
        cyc(0, 8'h00, 32'h0, 8'h00);
        expect_rd(8'h40, 32'h0000_9092, "R4 sticky across idle");
        cyc(1, 8'h44, 32'h0000_0200, 8'h00);
        expect_irq(1'b1, "R6 enable of pending source 1");

        cyc(1, 8'h48, 32'h0000_0002, 8'h02);
        expect_rd(8'h40, 32'h0000_9292, "R5 event beats clear");
        expect_irq(1'b1, "R5 irq stays high");
        cyc(1, 8'h48, 32'h0000_0002, 8'h00);
        expect_rd(8'h40, 32'h0000_9290, "R3 clear without event");

        cyc(1, 8'h20, 32'hFFFF_FFFF, 8'h00);
        expect_rd(8'h40, 32'h0000_9290, "R9 unmapped write ignored");
        expect_rd(8'h20, 32'h0, "R9 unmapped read zero");
        cyc(1, 8'h00, 32'h7FFF_FFFF, 8'h00);
        expect_rd(8'h00, 32'h0, "R8 zero in bit 31 no reset");
        expect_rd(8'h40, 32'h0000_9290, "R8 flags kept without reset");

        cyc(1, 8'h40, 32'h0000_6F6F, 8'h00);
        expect_irq(1'b1, "R6 all masked sources");

        cyc(1, 8'h04, 32'h8000_0000, 8'h00);
        expect_rd(8'h00, 32'h8000_0000, "R8 reset bit visible one cycle");
        expect_rd(8'h40, 32'h0, "R8 flags wiped");
        expect_rd(8'h00, 32'h0, "R8 reset bit self-cleared");
        expect_irq(1'b0, "R8 irq low after soft reset");

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule